// File: doc/BRIEF.md
# Local Interrupt Timer with Clock Divider

This block is a per-processor down-counting timer clocked from the bus clock through a power-of-two prescaler. Software programs a divide code, a timer entry and an initial count through a simple word-wide register port. The entry holds an 8-bit interrupt vector, a periodic/one-shot selector and a mask bit. Writing the initial count loads the counter and starts it. A separate current-count register shows the live value.

When the counter expires, the block raises a one-cycle interrupt request and presents the entry's vector with it. The request is raised only if the global software-enable bit is set and the entry is unmasked. In one-shot mode the counter then rests at zero. In periodic mode it reloads the initial count and keeps running. Delivery and arbitration of the request belong to the logic downstream.

Top module: `lt_timer`

## Requirements
- R1: After reset, every register reads 0 except the timer entry, which reads 0x100 (masked). Addresses: 0 control (bit 0 is software enable), 1 timer entry (bits 7:0 vector, bit 8 mask, bit 9 periodic), 2 initial count, 3 current count, 4 divide configuration. Addresses 5 to 7 read 0.
- R2: The divide code is {bit 3, bit 1, bit 0} of the divide register. The counter decrements once every 2^((code+1) mod 8) bus clocks, so code 7 divides by 1 and code 0 divides by 2.
- R3: A new divide code takes effect only at the next wrap of the prescaler. The period in progress finishes at the old rate.
- R4: On each enabled expiry, irq_o is high for the one cycle after the expiring edge. irq_vec_o holds the entry's vector from that cycle until the next request.
- R5: A write to the initial count loads the current count on the same edge. It overrides any decrement or expiry in that cycle. The current count register reads the live value.
- R6: In one-shot mode the counter goes from 1 to 0 with one request and then stays at 0.
- R7: In periodic mode the counter goes from 1 directly to the initial count and continues, with one request per period.
- R8: While the mask bit is set, an expiry raises no request, but the periodic reload still takes place.
- R9: While the software-enable bit is 0, an expiry raises no request.
- R10: Writing 0 to the initial count stops the timer with no request.
- R11: Writes to the current count register and to the unused addresses have no effect. Bit 2 and bits 31:4 of the divide register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address, shared by reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Interrupt request pulse |
| irq_vec_o | output | 8 | Vector of the latest request |

## Verification
The embedded assertions check several properties on every cycle:
- the counter holds between prescaler ticks;
- the counter stays at zero when it is idle;
- a periodic expiry reloads the initial count;
- the divide code in use changes only at a prescaler wrap;
- a request never appears while the timer is masked or disabled.

Other behaviours need the bench's scenarios. These are:
- the exact number of clocks per decrement for each divide code;
- the phase of a divide change;
- one request per one-shot run;
- the vector that accompanies a request;
- register readback, including ignored writes.

A behavioural model checks all of these against the ports on every clock.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int VEC_W  = 8;
  localparam int CODE_W = 3;
  localparam int PRE_W  = 8;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_ENTRY = 3'd1;
  localparam logic [2:0] A_INIT  = 3'd2;
  localparam logic [2:0] A_CUR   = 3'd3;
  localparam logic [2:0] A_DIV   = 3'd4;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } entry_t;

  function automatic logic [PRE_W-1:0] div_len(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] sh;
    sh = code + 3'd1;  // wraps: code 7 -> shift 0
    return PRE_W'(1) << sh;
  endfunction
endpackage

// File: rtl/lt_regs.sv
module lt_regs
  import lt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [DATA_W-1:0]     cur_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  sw_en_o,
  output entry_t                entry_o,
  output logic [DATA_W-1:0]     init_o,
  output logic [CODE_W-1:0]     code_o
);
  localparam int EW = $bits(entry_t);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_en_o <= 1'b0;
      entry_o <= '{periodic: 1'b0, mask: 1'b1, vec: '0};
      init_o  <= '0;
      code_o  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_W'(A_CTRL):  sw_en_o <= wdata_i[0];
        ADDR_W'(A_ENTRY): entry_o <= wdata_i[EW-1:0];
        ADDR_W'(A_INIT):  init_o  <= wdata_i;
        ADDR_W'(A_DIV):   code_o  <= {wdata_i[3], wdata_i[1:0]};
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(A_CTRL):  rdata_o[0] = sw_en_o;
      ADDR_W'(A_ENTRY): rdata_o[EW-1:0] = entry_o;
      ADDR_W'(A_INIT):  rdata_o = init_o;
      ADDR_W'(A_CUR):   rdata_o = cur_i;
      ADDR_W'(A_DIV):   rdata_o[3:0] = {code_o[2], 1'b0, code_o[1:0]};
      default: ;
    endcase
  end
endmodule

// File: rtl/lt_prescaler.sv
module lt_prescaler
  import lt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [PRE_W-1:0]  pre_q;
  logic [CODE_W-1:0] act_q;
  logic [PRE_W-1:0]  len;

  assign len    = div_len(act_q);
  assign tick_o = (pre_q == len - PRE_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      act_q <= '0;
    end else if (tick_o) begin
      pre_q <= '0;
      act_q <= code_i;  // new divide only at wrap
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  p_div_at_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(act_q));
endmodule

// File: rtl/lt_counter.sv
module lt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire_o = tick_i && (cur_o == ONE) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cur_o <= '0;
    else if (load_i)                 cur_o <= load_val_i;
    else if (tick_i && cur_o != '0) begin
      if (cur_o == ONE)              cur_o <= periodic_i ? init_i : '0;
      else                           cur_o <= cur_o - ONE;
    end
  end

  p_hold_between_ticks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cur_o));
  p_idle_stays_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_o == '0 && !load_i) |=> cur_o == '0);
  p_periodic_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && periodic_i) |=> cur_o == init_i);
endmodule

// File: rtl/lt_timer.sv
module lt_timer
  import lt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  logic              sw_en;
  entry_t            entry;
  logic [DATA_W-1:0] init_cnt, cur_cnt;
  logic [CODE_W-1:0] code;
  logic              tick, expire, init_wr, fire;

  assign init_wr = we_i && (addr_i == ADDR_W'(A_INIT));
  assign fire    = expire && sw_en && !entry.mask;

  lt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cur_i(cur_cnt), .rdata_o(rdata_o),
    .sw_en_o(sw_en), .entry_o(entry), .init_o(init_cnt), .code_o(code));

  lt_prescaler u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(code), .tick_o(tick));

  lt_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .load_i(init_wr),
    .load_val_i(wdata_i), .init_i(init_cnt), .periodic_i(entry.periodic),
    .cur_o(cur_cnt), .expire_o(expire));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      irq_o <= fire;
      if (fire) irq_vec_o <= entry.vec;
    end
  end

  p_no_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(entry.mask));
  p_no_irq_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(sw_en));
  p_irq_from_expiry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(expire));
endmodule

// File: tb/lt_timer_test.sv
`timescale 1ns/1ps
module lt_timer_test;
  logic        clk = 0, rst_n = 0, we = 0;
  logic [2:0]  addr = 3;
  logic [31:0] wdata = 0, rdata;
  logic        irq;
  logic [7:0]  irq_vec;
  int checks = 0, errors = 0, cycles = 0, irq_seen = 0;

  // behavioural model state
  int  m_pre = 0, m_act = 0, m_code = 0;
  logic [31:0] m_cur = 0, m_init = 0;
  bit  m_sw = 0, m_mask = 1, m_per = 0, m_irq = 0;
  logic [7:0] m_vec = 0, m_irqv = 0;

  always #4 clk = ~clk;

  lt_timer uut (.clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .irq_vec_o(irq_vec));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_act = 0; m_code = 0; m_cur = 0; m_init = 0;
      m_sw = 0; m_mask = 1; m_per = 0; m_irq = 0; m_vec = 0; m_irqv = 0;
    end else begin
      int  len;
      bit  tk, fire;
      len  = 1 << ((m_act + 1) % 8);
      tk   = (m_pre == len - 1);
      fire = 0;
      if (we && addr == 2) m_cur = wdata;
      else if (tk && m_cur != 0) begin
        if (m_cur == 1) begin
          fire  = m_sw && !m_mask;
          m_cur = m_per ? m_init : 0;
        end else m_cur = m_cur - 1;
      end
      if (tk) begin m_pre = 0; m_act = m_code; end else m_pre++;
      m_irq = fire;
      if (fire) m_irqv = m_vec;
      if (we) case (addr)
        0: m_sw = wdata[0];
        1: begin m_vec = wdata[7:0]; m_mask = wdata[8]; m_per = wdata[9]; end
        2: m_init = wdata;
        4: m_code = {wdata[3], wdata[1:0]};
        default: ;
      endcase
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n) begin
      chk("R4 R6 R7 R8 R9 irq", {31'b0, irq}, {31'b0, m_irq});
      chk("R4 vector", {24'b0, irq_vec}, {24'b0, m_irqv});
      if (!we && addr == 3) chk("R2 R3 R5 current count", rdata, m_cur);
      if (irq) irq_seen++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = 3;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
    addr = 3;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int k, base;
    idle(3); rst_n = 1; idle(1);
    // R1 reset values
    rd("R1 ctrl", 0, 0); rd("R1 entry", 1, 32'h100); rd("R1 init", 2, 0);
    rd("R1 cur", 3, 0); rd("R1 div", 4, 0); rd("R1 unused", 6, 0);
    // R11 divide readback, ignored writes
    wr(4, 32'hFFFF_FFFF); rd("R11 div readback", 4, 32'hB);
    wr(3, 32'h55); rd("R11 cur write ignored", 3, 0);
    wr(5, 32'h77); rd("R11 unused write ignored", 5, 0);
    // R2 R6 one-shot at divide 1 (code 7 written as 0xB)
    wr(0, 1); wr(1, 32'h042); idle(4);
    base = irq_seen;
    wr(2, 5);
    k = 0;
    for (int i = 1; i <= 20; i++) begin @(negedge clk); if (irq && k == 0) k = i; end
    chk("R2 clocks to expiry at divide 1", k, 5);
    chk("R6 one request", irq_seen - base, 1);
    rd("R6 rests at zero", 3, 0);
    chk("R4 vector", irq_vec, 8'h42);
    // R7 periodic at divide 2, R3 divide change mid-run
    wr(4, 0); wr(1, 32'h2A5);
    base = irq_seen; wr(2, 3); idle(40);
    checks++;
    if (irq_seen - base < 5) begin
      errors++; $display("FAIL R7 actual %0d expected >=5", irq_seen - base);
    end
    chk("R4 periodic vector", irq_vec, 8'hA5);
    wr(4, 32'h2); idle(50); wr(4, 32'h8); idle(30);
    // R8 masked periodic
    wr(1, 32'h311); base = irq_seen; idle(40);
    chk("R8 no request while masked", irq_seen - base, 0);
    @(negedge clk); #1; checks++;
    if (rdata == 0) begin errors++; $display("FAIL R8 actual 0 expected nonzero"); end
    // R9 software disable
    wr(0, 0); wr(1, 32'h011); wr(4, 32'hB); base = irq_seen;
    wr(2, 2); idle(20);
    chk("R9 no request while disabled", irq_seen - base, 0);
    // R10 init 0 stops
    wr(0, 1); wr(1, 32'h233); wr(2, 4); idle(12);
    wr(2, 0); base = irq_seen; idle(20);
    chk("R10 no request after stop", irq_seen - base, 0);
    rd("R10 stopped", 3, 0);
    // R5 load overrides a running count
    wr(2, 9); idle(2); wr(2, 100); rd("R5 reload", 2, 100);
    idle(10);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule